// File: doc/BRIEF.md
# Reset Supervisor Timing Controller

This block turns several reset sources into one stretched reset, held for a programmable number of clock cycles. The sources are a supply-undervoltage flag (already synchronous), a watchdog expiry pulse (synchronous), a manual reset request (active low, asynchronous) and the sampled levels of two shared reset lines. One line is active low and one is active high. The block drives both lines through open-drain enables, so each line is also an input. An external source that pulses a line starts the timer, and the block then holds that line itself.

A short pulse on a shared line is stretched to the full timeout. A pulse longer than the timeout ends the block's own drive when the timeout expires, and the line then returns to inactive only when the external source lets go. Level sources keep the timer reloaded while they are active: the undervoltage flag and the manual request both do this. The timeout length is picked from four elaboration-time cycle counts by a 2-bit select. The select is sampled whenever the timer loads.

Top module: `reset_stretch_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises with no source active, `drv_lo_o` and `drv_hi_o` are 0.
- R2: While `brownout_i` is 1 the outputs stay asserted. They become asserted in the cycle after the first high sample and release exactly TMO cycles after the last high sample.
- R3: A 0-to-1 change in the asserted state of the active-low line (`line_n_i` going low) asserts the outputs 3 cycles later and holds them for TMO cycles, even if the external pulse is shorter than that.
- R4: If the active-low line is held low externally for longer than the timeout, the drive ends after TMO cycles and is not restarted while the external low persists.
- R5: `man_req_n_i` is synchronised through two flops. Every cycle it reads 0 reloads the timer, so the outputs assert 3 cycles after it falls and release TMO cycles after the last synchronised low sample.
- R6: A one-cycle high on `wdog_i` asserts the outputs in the next cycle for exactly TMO cycles.
- R7: `drv_hi_o` always equals `drv_lo_o`: the active-high line is driven with inverted line polarity under the same rules.
- R8: A rise of the active-high line (`line_p_i` going high) triggers a TMO-cycle run 3 cycles later, like R3.
- R9: The block's own drive, read back on a line, does not retrigger the timer. A run started by any source therefore ends after TMO cycles with no follow-on run.
- R10: `tmo_sel_i` sampled at the triggering edge picks TMO: code 0 gives 8 cycles, 1 gives 20, 2 gives 50 and 3 gives 120 (default parameters).
- R11: A new trigger during a run reloads the full TMO count from that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| brownout_i | input | 1 | Supply-undervoltage flag, active high, synchronous |
| wdog_i | input | 1 | Watchdog expiry pulse, synchronous |
| man_req_n_i | input | 1 | Manual reset request, active low, asynchronous |
| line_n_i | input | 1 | Sampled level of the shared active-low reset line |
| line_p_i | input | 1 | Sampled level of the shared active-high reset line |
| tmo_sel_i | input | 2 | Timeout select code |
| drv_lo_o | output | 1 | 1 = pull the active-low line low |
| drv_hi_o | output | 1 | 1 = pull the active-high line high |

## Verification
The undervoltage flag and the watchdog pulse take effect one cycle after the cycle in which they are applied. The manual request and both lines pass through the two synchroniser flops and take effect three cycles after they are applied. Each release comes TMO cycles after the last trigger sample. For every stimulus the driver works out the start cycle and the run length from these latencies and queues them. The monitor samples on the falling clock edge, timestamps each rise and fall of the drive, and compares the measured start and length against the queued values. Any run that appears with nothing queued is counted as a failure, which is how R4 and R9 are caught.

// File: rtl/rsc_pkg.sv
// Package: shared types and helpers for the reset supervisor timing controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rsc_pkg;

    // Trigger bus from the source stage to the timer.
    typedef struct packed {
        logic hold;   // level source active: keep reloading
        logic pulse;  // single-cycle start event
    } rsc_trig_t;

    // Largest of four cycle counts, used to size the timer.
    function automatic int unsigned rsc_max4(input int unsigned a, input int unsigned b,
                                             input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rsc_sync.sv
// Module: multi-bit flop-chain synchroniser, each bit independent.
// Assumes: bits are unrelated levels; reset value is all zeros (inactive).
module rsc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/rsc_trigger.sv
// Module: turns raw reset sources into hold/pulse triggers.
// Level sources (undervoltage, manual) produce hold; line assertions and the
// watchdog produce pulse. Line rises seen while the block itself drives are
// dropped, since they are its own drive read back.
// Assumes: brownout_i and wdog_i are synchronous; every timeout is longer
// than SYNC_STAGES+1 cycles so the echo of the drive lands inside the run.
module rsc_trigger
    import rsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      brownout_i,
    input  logic      wdog_i,
    input  logic      man_req_n_i,
    input  logic      line_n_i,
    input  logic      line_p_i,
    input  logic      own_drive_i,
    output rsc_trig_t trig_o
);

    localparam int NSRC = 3;   // [0] manual, [1] low line, [2] high line

    logic [NSRC-1:0] raw_act;
    logic [NSRC-1:0] syn_act;
    logic [1:0]      line_prev;
    logic [1:0]      line_rise;

    // Convert every asynchronous source to "asserted = 1" before syncing.
    assign raw_act = {line_p_i, ~line_n_i, ~man_req_n_i};

    rsc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_act),
        .q_o   (syn_act)
    );

    // Remember last synchronised line state for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_prev <= '0;
        end else begin
            line_prev <= syn_act[2:1];
        end
    end

    assign line_rise = syn_act[2:1] & ~line_prev;

    // Merge sources into the trigger bus, masking line echoes of own drive.
    always_comb begin
        trig_o.hold  = brownout_i | syn_act[0];
        trig_o.pulse = wdog_i | ((|line_rise) & ~own_drive_i);
    end

endmodule

// File: rtl/rsc_timer.sv
// Module: reset stretch timer. Any trigger loads the selected count and
// sets the run flag; the run ends once the count has been walked to zero.
// Assumes: all four counts are at least 1; select is sampled on load only.
module rsc_timer
    import rsc_pkg::*;
#(
    parameter int unsigned TMO0 = 8,
    parameter int unsigned TMO1 = 20,
    parameter int unsigned TMO2 = 50,
    parameter int unsigned TMO3 = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  rsc_trig_t  trig_i,
    input  logic [1:0] sel_i,
    output logic       run_o
);

    localparam int unsigned TMO_MAX = rsc_max4(TMO0, TMO1, TMO2, TMO3);
    localparam int          CW      = $clog2(TMO_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    // Pick the reload value (count minus one) for the selected code.
    always_comb begin
        unique case (sel_i)
            2'd0:    load_val = CW'(TMO0 - 1);
            2'd1:    load_val = CW'(TMO1 - 1);
            2'd2:    load_val = CW'(TMO2 - 1);
            default: load_val = CW'(TMO3 - 1);
        endcase
    end

    // Load on any trigger, otherwise count the run down to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o <= 1'b0;
            cnt   <= '0;
        end else if (trig_i.hold || trig_i.pulse) begin
            run_o <= 1'b1;
            cnt   <= load_val;
        end else if (run_o) begin
            if (cnt == '0) begin
                run_o <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/reset_stretch_ctrl.sv
// Module: top of the reset supervisor timing controller. Drives a shared
// active-low and a shared active-high reset line (open-drain enables) for a
// programmable stretch after any source: undervoltage, watchdog, manual
// request, or an external assertion of either line.
// Assumes: brownout_i/wdog_i synchronous to clk; the other inputs are
// asynchronous; every TMOx > SYNC_STAGES+1.
module reset_stretch_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned TMO0        = 8,
    parameter int unsigned TMO1        = 20,
    parameter int unsigned TMO2        = 50,
    parameter int unsigned TMO3        = 120,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       brownout_i,
    input  logic       wdog_i,
    input  logic       man_req_n_i,
    input  logic       line_n_i,
    input  logic       line_p_i,
    input  logic [1:0] tmo_sel_i,
    output logic       drv_lo_o,
    output logic       drv_hi_o
);

    rsc_trig_t trig;
    logic      run;

    rsc_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .brownout_i  (brownout_i),
        .wdog_i      (wdog_i),
        .man_req_n_i (man_req_n_i),
        .line_n_i    (line_n_i),
        .line_p_i    (line_p_i),
        .own_drive_i (run),
        .trig_o      (trig)
    );

    rsc_timer #(.TMO0(TMO0), .TMO1(TMO1), .TMO2(TMO2), .TMO3(TMO3)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig),
        .sel_i  (tmo_sel_i),
        .run_o  (run)
    );

    // Both line enables follow the single run flag.
    assign drv_lo_o = run;
    assign drv_hi_o = run;

endmodule

// File: rtl/rsc_checker.sv
// Module: assertion checker for reset_stretch_ctrl, attached by bind.
// Assumes: the two-flop synchroniser of the default configuration.
module rsc_checker (
    input logic clk,
    input logic rst_n,
    input logic brownout_i,
    input logic wdog_i,
    input logic man_req_n_i,
    input logic drv_lo_o
);

    // R1: first cycle out of reset has no drive.
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !drv_lo_o);

    // R2: undervoltage sample forces drive in the next cycle.
    assert_brownout_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        brownout_i |=> drv_lo_o);

    // R2: drive never ends right after an undervoltage sample.
    assert_no_release_in_brownout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_lo_o) |-> !$past(brownout_i));

    // R6: watchdog expiry drives in the next cycle.
    assert_wdog_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_i |=> drv_lo_o);

    // R5: a manual low seen for three samples out of reset means drive.
    assert_manual_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_req_n_i && $past(!man_req_n_i) && $past(!man_req_n_i, 2)
         && $past(rst_n) && $past(rst_n, 2)) |=> drv_lo_o);

endmodule

bind reset_stretch_ctrl rsc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .brownout_i  (brownout_i),
    .wdog_i      (wdog_i),
    .man_req_n_i (man_req_n_i),
    .drv_lo_o    (drv_lo_o)
);

// File: tb/sim_reset_stretch_ctrl.sv
// Bench: scoreboard. Drivers queue the expected run (start cycle, length);
// a negedge monitor measures each run of drv_lo_o and compares.
module sim_reset_stretch_ctrl;

    typedef struct {
        int    start;
        int    len;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       brownout = 1'b0;
    logic       wdog = 1'b0;
    logic       man_n = 1'b1;
    logic       ext_lo = 1'b0;
    logic       ext_hi = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       drv_lo, drv_hi;
    wire        line_n = ~(ext_lo | drv_lo);
    wire        line_p = ext_hi | drv_hi;

    int   cyc = 0;
    int   tests = 0;
    int   fails = 0;
    int   mirror_bad = 0;
    int   run_start = 0;
    logic prev_drv = 1'b0;
    exp_t expq[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    reset_stretch_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .brownout_i  (brownout),
        .wdog_i      (wdog),
        .man_req_n_i (man_n),
        .line_n_i    (line_n),
        .line_p_i    (line_p),
        .tmo_sel_i   (sel),
        .drv_lo_o    (drv_lo),
        .drv_hi_o    (drv_hi)
    );

    function automatic int tmo_of(input logic [1:0] s);
        case (s)
            2'd0:    return 8;
            2'd1:    return 20;
            2'd2:    return 50;
            default: return 120;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Monitor: time each run and compare with the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (drv_hi !== drv_lo) mirror_bad++;
            if (drv_lo && !prev_drv) run_start = cyc;
            if (!drv_lo && prev_drv) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 unexpected run", cyc - run_start, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(run_start == e.start, {e.req, " start"}, run_start, e.start);
                    check((cyc - run_start) == e.len, {e.req, " length"}, cyc - run_start, e.len);
                end
            end
        end
        prev_drv = drv_lo;
    end

    task automatic idle_wait();
        while (drv_lo || expq.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic push_exp(input int s, input int l, input string r);
        exp_t e;
        e.start = s; e.len = l; e.req = r;
        expq.push_back(e);
    endtask

    task automatic do_wdog(input logic [1:0] s, input string r);
        sel = s;
        push_exp(cyc + 1, tmo_of(s), r);
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        idle_wait();
    endtask

    task automatic do_brownout(input int h);
        push_exp(cyc + 1, h - 1 + tmo_of(sel), "R2");
        brownout = 1'b1;
        repeat (h) @(negedge clk);
        brownout = 1'b0;
        idle_wait();
    endtask

    task automatic do_manual(input int h);
        push_exp(cyc + 3, h - 1 + tmo_of(sel), "R5");
        man_n = 1'b0;
        repeat (h) @(negedge clk);
        man_n = 1'b1;
        idle_wait();
    endtask

    task automatic do_line(input bit hi_line, input int h, input string r);
        push_exp(cyc + 3, tmo_of(sel), r);
        if (hi_line) ext_hi = 1'b1; else ext_lo = 1'b1;
        repeat (h) @(negedge clk);
        ext_hi = 1'b0;
        ext_lo = 1'b0;
        idle_wait();
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(drv_lo == 1'b0 && drv_hi == 1'b0, "R1 in reset", drv_lo, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(drv_lo == 1'b0 && drv_hi == 1'b0, "R1 after reset", drv_lo, 0);

        // R6 / R10: watchdog with each timeout code.
        do_wdog(2'd0, "R6 R10 sel0");
        do_wdog(2'd1, "R10 sel1");
        do_wdog(2'd2, "R10 sel2");
        do_wdog(2'd3, "R10 sel3");

        // R9: own drive read back must not start another run.
        sel = 2'd0;
        do_wdog(2'd0, "R9");
        repeat (10) begin
            @(negedge clk);
            if (drv_lo) break;
        end
        check(drv_lo == 1'b0, "R9 no retrigger", drv_lo, 0);

        // R2: undervoltage held for two different lengths.
        do_brownout(1);
        do_brownout(30);

        // R5: manual request short and long.
        do_manual(2);
        do_manual(25);

        // R3: short pulse on low line stretched.
        do_line(1'b0, 2, "R3 short");

        // R4: long pulse on low line; drive ends, line stays low externally.
        sel = 2'd0;
        push_exp(cyc + 3, tmo_of(2'd0), "R4 long");
        ext_lo = 1'b1;
        repeat (20) @(negedge clk);
        check(drv_lo == 1'b0, "R4 drive released", drv_lo, 0);
        check(line_n == 1'b0, "R4 line follows external", line_n, 0);
        ext_lo = 1'b0;
        repeat (2) @(negedge clk);
        check(line_n == 1'b1, "R4 line returns high", line_n, 1);
        idle_wait();

        // R8: active-high line, short and long.
        do_line(1'b1, 1, "R8 short");
        do_line(1'b1, 30, "R8 long");

        // R11: second watchdog five cycles into a run reloads the count.
        sel = 2'd0;
        push_exp(cyc + 1, 5 + tmo_of(2'd0), "R11");
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        repeat (4) @(negedge clk);
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        idle_wait();

        // R10: select changed during a run does not alter it (sampled at load).
        sel = 2'd0;
        push_exp(cyc + 1, tmo_of(2'd0), "R10 sampled at load");
        wdog = 1'b1;
        @(negedge clk);
        wdog = 1'b0;
        sel = 2'd3;
        idle_wait();

        check(mirror_bad == 0, "R7 high drive mirrors low drive", mirror_bad, 0);
        check(expq.size() == 0, "scoreboard drained", expq.size(), 0);
        summary();
        $finish;
    end

endmodule